// File: doc/BRIEF.md
# Byte-Wide EEPROM Erase/Program Sequencer

This controller sits between a host that issues single memory operations and a byte-wide electrically erasable memory. The host presents a command, an address, write data and a one-cycle start strobe. The controller then produces the memory's chip-enable, output-enable, programming-voltage enable, address and data-bus controls. When the operation completes, it returns a one-cycle done pulse together with the read data and the error and verify flags.

A byte write is never issued on its own. The controller first runs an erase pass that drives all-ones data. It then runs a program pass that drives the requested byte. If the host asked for it, a read-back of the same address follows at once, and the result is compared with the requested byte.

A chip-erase command runs a single all-ones pass with a dedicated chip-erase output raised. The programming voltage is gated by a supply-good input, and its pulse is held to a capped cycle count. Setup and hold windows keep the address and data still around every pulse. All durations are cycle-count parameters.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, and in every cycle the controller is idle, the outputs are mem_ce_n=1, mem_oe_n=1, mem_vpp_en=0, mem_dq_oe=0 and busy=0.
- R2: A read (cmd 2'b00, with 2'b11 treated the same) lowers mem_ce_n first. It lowers mem_oe_n exactly OE_LAG_CYC cycles later and holds it low for ACC_CYC cycles. The bus is sampled in the last of those cycles and returned on rdata with done. mem_dq_oe is 0 whenever mem_oe_n is 0.
- R3: A byte write (cmd 2'b01) produces exactly two programming pulses at the same address. The first carries data 8'hFF (the erase pass) and the second carries wdata (the program pass).
- R4: Around every pulse, the address and driven data hold still, with mem_ce_n low and mem_dq_oe high. This lasts for at least SETUP_CYC cycles before mem_vpp_en rises, throughout the pulse, and for at least HOLD_CYC cycles after it falls.
- R5: Each pulse lasts min(PULSE_CYC, PULSE_MAX_CYC) cycles and never longer than PULSE_MAX_CYC.
- R6: mem_vpp_en is high only while supply_ok is high. A write or chip-erase started with supply_ok low raises no pulse, leaves memory unchanged and ends with done and error both 1.
- R7: A chip erase (cmd 2'b10) produces one pulse with mem_chip_erase high and data all ones. mem_chip_erase is 0 outside that operation.
- R8: With verify_en=1, the read-back starts straight after the program hold. mem_oe_n falls HOLD_CYC+OE_LAG_CYC cycles after mem_vpp_en falls. verify_fail is 1 with done exactly when the byte read differs from wdata. With verify_en=0, mem_oe_n stays high for the whole write.
- R9: busy rises in the cycle after an accepted start and stays high up to and including the done cycle. A start strobe seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, sampled when idle |
| cmd | input | 2 | 00 read, 01 byte write, 10 chip erase, 11 read |
| addr | input | AW | Byte address |
| wdata | input | DW | Byte to write |
| verify_en | input | 1 | Read back and compare after a byte write |
| supply_ok | input | 1 | Supply-good, gates the programming voltage |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With done: rejected or supply lost |
| verify_fail | output | 1 | With done: read-back mismatch |
| rdata | output | DW | Last byte read from the memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_vpp_en | output | 1 | Programming-voltage enable |
| mem_chip_erase | output | 1 | Chip-erase level request for the output-enable pin |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data-bus drive enable |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
The bench writes over a byte that already holds cleared bits, in a memory model that can only clear bits when programming. A sequencer that skipped or misordered the erase pass would therefore store the wrong value and fail the read-back. A stuck-bit fault in the model checks that verify_fail reports a real mismatch. A controller that compared against the wrong byte or captured the bus too early would miss it.

Rejection with supply_ok low must leave memory untouched and raise no pulse. A start strobe injected mid-write must not trigger a second access. The gap between the end of the program pulse and the read-back is measured so that an inserted recovery wait shows up. The pulse width is measured with the requested width above the cap, so a missing clamp is visible.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_CHIP  = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_PULSE = 3'd2,
    S_HOLD  = 3'd3,
    S_RLAG  = 3'd4,
    S_RACC  = 3'd5,
    S_DONE  = 3'd6
  } state_e;

endpackage

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eeprom_seq_capture.sv
module eeprom_seq_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_en,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] expect_val,
  output logic [DW-1:0] rdata,
  output logic          mismatch
);

  logic [DW-1:0] rdata_d;
  logic          mism_d;

  always_comb begin
    rdata_d = bus_in;
    mism_d  = (bus_in != expect_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      mismatch <= 1'b0;
    end else if (capture_en) begin
      rdata    <= rdata_d;
      mismatch <= mism_d;
    end
  end

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int AW            = 11,
  parameter int DW            = 8,
  parameter int SETUP_CYC     = 2,
  parameter int HOLD_CYC      = 2,
  parameter int PULSE_CYC     = 8,
  parameter int PULSE_MAX_CYC = 6,
  parameter int OE_LAG_CYC    = 1,
  parameter int ACC_CYC       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          verify_en,
  input  logic          supply_ok,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          verify_fail,
  output logic [DW-1:0] rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_vpp_en,
  output logic          mem_chip_erase,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int PW_CYC = (PULSE_CYC < PULSE_MAX_CYC) ? PULSE_CYC : PULSE_MAX_CYC;
  localparam int D_A    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int D_B    = (OE_LAG_CYC > ACC_CYC) ? OE_LAG_CYC : ACC_CYC;
  localparam int D_C    = (D_A > D_B) ? D_A : D_B;
  localparam int D_MAX  = (D_C > PW_CYC) ? D_C : PW_CYC;
  localparam int TW     = $clog2(D_MAX + 1);

  localparam logic [TW-1:0] L_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] L_PULSE = TW'(PW_CYC - 1);
  localparam logic [TW-1:0] L_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] L_LAG   = TW'(OE_LAG_CYC - 1);
  localparam logic [TW-1:0] L_ACC   = TW'(ACC_CYC - 1);

  state_e        st_q, st_d;
  cmd_e          op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          ven_q, ven_d;
  logic          pass_q, pass_d;   // 0 erase pass, 1 program pass
  logic          vfy_q, vfy_d;     // current read is a write read-back
  logic          err_q, err_d;
  logic          t_load, t_exp, cap_en;
  logic [TW-1:0] t_val;
  logic          mism;
  logic          accept;
  logic          hv_phase;

  eeprom_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  eeprom_seq_capture #(.DW(DW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (cap_en),
    .bus_in     (mem_dq_in),
    .expect_val (wd_q),
    .rdata      (rdata),
    .mismatch   (mism)
  );

  assign accept = (st_q == S_IDLE) && start;

  // next-state process
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    ven_d  = ven_q;
    pass_d = pass_q;
    vfy_d  = vfy_q;
    err_d  = err_q;
    t_load = 1'b0;
    t_val  = '0;
    cap_en = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          op_d   = cmd_e'(cmd);
          addr_d = addr;
          wd_d   = wdata;
          ven_d  = verify_en;
          pass_d = 1'b0;
          vfy_d  = 1'b0;
          err_d  = 1'b0;
          if (cmd_e'(cmd) == CMD_WRITE || cmd_e'(cmd) == CMD_CHIP) begin
            if (!supply_ok) begin
              err_d = 1'b1;
              st_d  = S_DONE;
            end else begin
              st_d   = S_SETUP;
              t_load = 1'b1;
              t_val  = L_SETUP;
            end
          end else begin
            st_d   = S_RLAG;
            t_load = 1'b1;
            t_val  = L_LAG;
          end
        end
      end
      S_SETUP: begin
        if (t_exp) begin
          st_d   = S_PULSE;
          t_load = 1'b1;
          t_val  = L_PULSE;
        end
      end
      S_PULSE: begin
        if (!supply_ok) err_d = 1'b1;
        if (t_exp) begin
          st_d   = S_HOLD;
          t_load = 1'b1;
          t_val  = L_HOLD;
        end
      end
      S_HOLD: begin
        if (t_exp) begin
          if (op_q == CMD_WRITE && !pass_q) begin
            pass_d = 1'b1;
            st_d   = S_SETUP;
            t_load = 1'b1;
            t_val  = L_SETUP;
          end else if (op_q == CMD_WRITE && ven_q) begin
            vfy_d  = 1'b1;
            st_d   = S_RLAG;
            t_load = 1'b1;
            t_val  = L_LAG;
          end else begin
            st_d = S_DONE;
          end
        end
      end
      S_RLAG: begin
        if (t_exp) begin
          st_d   = S_RACC;
          t_load = 1'b1;
          t_val  = L_ACC;
        end
      end
      S_RACC: begin
        if (t_exp) begin
          cap_en = 1'b1;
          st_d   = S_DONE;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pass_q <= 1'b0;
      vfy_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      vfy_q  <= vfy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= CMD_READ;
      addr_q <= '0;
      wd_q   <= '0;
      ven_q  <= 1'b0;
    end else if (accept) begin
      op_q   <= op_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      ven_q  <= ven_d;
    end
  end

  // output decode
  assign hv_phase       = (st_q == S_SETUP) || (st_q == S_PULSE) || (st_q == S_HOLD);
  assign busy           = (st_q != S_IDLE);
  assign done           = (st_q == S_DONE);
  assign error          = done && err_q;
  assign verify_fail    = done && vfy_q && mism;
  assign mem_ce_n       = !(hv_phase || (st_q == S_RLAG) || (st_q == S_RACC));
  assign mem_oe_n       = (st_q != S_RACC);
  assign mem_vpp_en     = (st_q == S_PULSE) && supply_ok;
  assign mem_dq_oe      = hv_phase;
  assign mem_chip_erase = hv_phase && (op_q == CMD_CHIP);
  assign mem_addr       = addr_q;
  assign mem_dq_out     = (op_q == CMD_CHIP || !pass_q) ? {DW{1'b1}} : wd_q;

endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk #(
  parameter int AW            = 11,
  parameter int DW            = 8,
  parameter int PULSE_MAX_CYC = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          supply_ok,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_vpp_en,
  input logic          mem_dq_oe,
  input logic          mem_chip_erase,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out
);

  localparam int CW = $clog2(PULSE_MAX_CYC + 2) + 1;

  logic [CW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vcnt <= '0;
    else if (mem_vpp_en) vcnt <= vcnt + CW'(1);
    else                 vcnt <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_oe_n && !mem_vpp_en && !mem_dq_oe));

  assert_read_bus_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_vpp_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vpp_en |-> (!mem_ce_n && mem_dq_oe));

  assert_vpp_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_vpp_en) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $past(mem_dq_oe)));

  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vpp_en |-> (vcnt < CW'(PULSE_MAX_CYC)));

  assert_vpp_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vpp_en |-> supply_ok);

  assert_chip_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_chip_erase |-> (mem_dq_oe && (mem_dq_out == {DW{1'b1}})));

  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

bind eeprom_seq eeprom_seq_chk #(
  .AW(AW), .DW(DW), .PULSE_MAX_CYC(PULSE_MAX_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .done           (done),
  .supply_ok      (supply_ok),
  .mem_ce_n       (mem_ce_n),
  .mem_oe_n       (mem_oe_n),
  .mem_vpp_en     (mem_vpp_en),
  .mem_dq_oe      (mem_dq_oe),
  .mem_chip_erase (mem_chip_erase),
  .mem_addr       (mem_addr),
  .mem_dq_out     (mem_dq_out)
);

// File: tb/eeprom_seq_test.sv
`timescale 1ns/1ps
module eeprom_seq_test;

  localparam int AW = 11, DW = 8;
  localparam int SETUP = 2, HOLD = 2, PW = 6, LAG = 1, ACC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, verify_en = 1'b0, supply_ok = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, error, verify_fail, mem_ce_n, mem_oe_n, mem_vpp_en, mem_chip_erase, mem_dq_oe;
  logic [DW-1:0] rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  eeprom_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .wdata(wdata),
    .verify_en(verify_en), .supply_ok(supply_ok), .busy(busy), .done(done), .error(error),
    .verify_fail(verify_fail), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_vpp_en(mem_vpp_en), .mem_chip_erase(mem_chip_erase), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: programming can only clear bits
  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] fault = 8'h00;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : 8'h00;

  int checks = 0, fails = 0, cyc = 0;
  int n_pulse, n_ff, min_setup, min_hold, min_len, max_len, n_oe_fall, last_lag, last_acc;
  int last_gap, chip_seen, bad_stable, bad_bus, bad_idle, pre, len, hold, gap, lag, acc;
  bit hold_act, gap_act, p_vpp, p_oe_n, p_drv;
  logic [7:0] pd, first_dq, last_dq, p_dq;
  logic [AW-1:0] pa, p_addr;
  bit pchip;
  logic res_err, res_vf;
  logic [7:0] res_rd;
  int busy_gap, n_done;

  task automatic clear_stats();
    n_pulse = 0; n_ff = 0; min_setup = 999; min_hold = 999; min_len = 999; max_len = 0;
    n_oe_fall = 0; last_lag = -1; last_acc = -1; last_gap = -1; chip_seen = 0;
    bad_stable = 0; bad_bus = 0; bad_idle = 0; busy_gap = 0; n_done = 0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bus monitor, sampled mid-cycle
  always @(negedge clk) begin
    bit drv;
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
    if (rst_n) begin
      drv = !mem_ce_n && mem_dq_oe && !mem_vpp_en;
      if (mem_vpp_en && !p_vpp) begin
        if (pre < min_setup) min_setup = pre;
        n_pulse++; len = 0; pa = mem_addr; pd = mem_dq_out; pchip = mem_chip_erase;
        if (mem_dq_out == 8'hFF && !mem_chip_erase) n_ff++;
        if (n_pulse == 1) first_dq = mem_dq_out;
        last_dq = mem_dq_out; gap_act = 0; hold_act = 0;
      end
      if (mem_vpp_en) begin
        len++;
        if (mem_addr != pa || mem_dq_out != pd || !mem_dq_oe || mem_ce_n) bad_stable++;
        if (mem_chip_erase) chip_seen++;
      end
      if (!mem_vpp_en && p_vpp) begin
        if (len < min_len) min_len = len;
        if (len > max_len) max_len = len;
        if (pchip) for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
        else if (pd == 8'hFF) mem[pa] = 8'hFF;
        else mem[pa] = mem[pa] & pd & ~fault;
        hold_act = 1; hold = 0; gap_act = 1; gap = 0;
      end
      if (hold_act) begin
        if (drv && mem_addr == pa && mem_dq_out == pd) hold++;
        else begin
          if (hold < min_hold) min_hold = hold;
          hold_act = 0;
        end
      end
      if (gap_act) begin
        if (!mem_oe_n) begin last_gap = gap; gap_act = 0; end
        else if (busy) gap++;
        else gap_act = 0;
      end
      if (drv) pre = (p_drv && mem_addr == p_addr && mem_dq_out == p_dq) ? pre + 1 : 1;
      else pre = 0;
      if (!mem_oe_n && p_oe_n) begin last_lag = lag; n_oe_fall++; end
      lag = (!mem_ce_n && mem_oe_n && !mem_dq_oe) ? lag + 1 : 0;
      if (!mem_oe_n) acc++;
      else if (!p_oe_n) begin last_acc = acc; acc = 0; end
      if (!mem_oe_n && mem_dq_oe) bad_bus++;
      if (!busy && (!mem_ce_n || !mem_oe_n || mem_vpp_en || mem_dq_oe)) bad_idle++;
      p_vpp = mem_vpp_en; p_oe_n = mem_oe_n; p_drv = drv; p_addr = mem_addr; p_dq = mem_dq_out;
    end
  end

  // issue one operation; optionally poke a second start while busy
  task automatic run_op(input logic [1:0] c, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic ve, input int poke);
    int w;
    @(negedge clk);
    cmd = c; addr = a; wdata = d; verify_en = ve; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 500) begin
      if (!busy) busy_gap++;
      if (w == poke) begin cmd = 2'b00; addr = a + 11'd1; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      w++;
    end
    start = 1'b0;
    check(done === 1'b1, "R9 done reached", w, 0);
    res_err = error; res_vf = verify_fail; res_rd = rdata;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) n_done++;
    end
  endtask

  task automatic t_reset();
    check(busy == 0 && mem_ce_n == 1 && mem_oe_n == 1 && mem_vpp_en == 0 && mem_dq_oe == 0 && done == 0,
          "R1 reset outputs", {busy, mem_ce_n, mem_oe_n, mem_vpp_en, mem_dq_oe}, 8'b01100);
  endtask

  task automatic t_read();
    clear_stats(); mem[11'h123] = 8'h5A;
    run_op(2'b00, 11'h123, 8'h00, 1'b0, -1);
    check(res_rd == 8'h5A, "R2 read data", res_rd, 8'h5A);
    check(last_lag == LAG, "R2 oe lag", last_lag, LAG);
    check(last_acc == ACC, "R2 access length", last_acc, ACC);
    check(bad_bus == 0 && n_pulse == 0, "R2 bus released", bad_bus, 0);
    check(res_err == 0, "R2 no error", res_err, 0);
  endtask

  task automatic t_write_verify();
    clear_stats(); mem[11'h045] = 8'hC3;
    run_op(2'b01, 11'h045, 8'h3C, 1'b1, -1);
    check(mem[11'h045] == 8'h3C, "R3 stored byte", mem[11'h045], 8'h3C);
    check(n_pulse == 2 && first_dq == 8'hFF && last_dq == 8'h3C, "R3 erase then program", n_pulse, 2);
    check(min_setup >= SETUP && min_hold >= HOLD && bad_stable == 0, "R4 setup/hold", min_setup, SETUP);
    check(min_len == PW && max_len == PW, "R5 pulse width capped", max_len, PW);
    check(last_gap == HOLD + LAG, "R8 immediate read-back", last_gap, HOLD + LAG);
    check(res_vf == 0 && res_rd == 8'h3C, "R8 verify pass", res_vf, 0);
    check(busy_gap == 0 && bad_idle == 0, "R9 busy continuous", busy_gap, 0);
  endtask

  task automatic t_write_noverify();
    clear_stats(); mem[11'h2A0] = 8'h0F;
    run_op(2'b01, 11'h2A0, 8'hA5, 1'b0, -1);
    check(mem[11'h2A0] == 8'hA5, "R3 stored byte no verify", mem[11'h2A0], 8'hA5);
    check(n_oe_fall == 0, "R8 no read-back when disabled", n_oe_fall, 0);
  endtask

  task automatic t_reject();
    clear_stats(); supply_ok = 1'b0; mem[11'h010] = 8'h77;
    run_op(2'b01, 11'h010, 8'h11, 1'b1, -1);
    check(res_err == 1, "R6 write rejected flag", res_err, 1);
    check(n_pulse == 0 && mem[11'h010] == 8'h77, "R6 no pulse, memory kept", n_pulse, 0);
    run_op(2'b10, 11'h000, 8'h00, 1'b0, -1);
    check(res_err == 1 && n_pulse == 0 && mem[11'h010] == 8'h77, "R6 chip erase rejected", n_pulse, 0);
    supply_ok = 1'b1;
  endtask

  task automatic t_verify_fail();
    clear_stats(); fault = 8'h01; mem[11'h300] = 8'h00;
    run_op(2'b01, 11'h300, 8'h81, 1'b1, -1);
    fault = 8'h00;
    check(res_vf == 1, "R8 mismatch flagged", res_vf, 1);
    check(res_rd == 8'h80, "R8 read-back value", res_rd, 8'h80);
  endtask

  task automatic t_chip();
    clear_stats(); mem[11'h001] = 8'h12; mem[11'h7FF] = 8'h00;
    run_op(2'b10, 11'h001, 8'h00, 1'b0, -1);
    check(n_pulse == 1 && chip_seen == PW, "R7 single chip pulse", chip_seen, PW);
    check(mem[11'h001] == 8'hFF && mem[11'h7FF] == 8'hFF, "R7 array erased", mem[11'h7FF], 8'hFF);
    check(res_err == 0 && mem_chip_erase == 0, "R7 flag idle low", mem_chip_erase, 0);
  endtask

  task automatic t_busy_ignore();
    clear_stats(); mem[11'h400] = 8'h00;
    run_op(2'b01, 11'h400, 8'h6E, 1'b0, 5);
    check(n_oe_fall == 0, "R9 start while busy ignored", n_oe_fall, 0);
    check(n_done == 0 && busy == 0, "R9 no second operation", n_done, 0);
    check(mem[11'h400] == 8'h6E, "R9 write intact", mem[11'h400], 8'h6E);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    p_vpp = 0; p_oe_n = 1; p_drv = 0; pre = 0; lag = 0; acc = 0; hold_act = 0; gap_act = 0;
    p_addr = '0; p_dq = '0; pa = '0; pd = '0; pchip = 0; len = 0; hold = 0; gap = 0;
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write_verify();
    t_write_noverify();
    t_reject();
    t_verify_fail();
    t_chip();
    t_busy_ignore();
    check(bad_idle == 0, "R1 idle outputs quiet", bad_idle, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule